// File: doc/BRIEF.md
# Write-to-Read Latency Tracker

This block keeps the timing of operand reads that wait on one or more producing writes. It holds a table of write slots and a table of read slots. A read slot is linked to a write slot with a signed read-advance. The link shortens the read's wait when the advance is positive and lengthens it when the advance is negative. A write slot's remaining-cycle count is unknown until the write is issued with its latency. From then on the count falls by one on every tick, and it may go below zero.

A read can depend on several partial writes. It stays unknown until every write it is linked to has issued. Its wait is then the largest of the per-write delays. Each per-write delay is the write's remaining count minus the link's advance, with a floor of zero. A link to a write that has already issued reports its delay at once and is not stored. After a read becomes known, its count falls by one per tick until it reaches zero, and at zero the read is ready. The block tracks timing only. It carries no data values and does no renaming or scheduling.

Every update is registered. A link, an issue or a tick on one clock edge shows on the outputs straight after that edge.

Top module: `lat_trk`

## Requirements
- R1: After reset, and whenever a read is not known, the read reports not known, not ready and zero cycles, and `link_err_o` is 0.
- R2: A read linked to a write that has not issued stays not known. When that write issues with latency L, the read becomes known one cycle later with cycles max(0, L - A), where A is the signed two's-complement advance of the link.
- R3: A negative advance lengthens the wait. With A < 0 the reported cycles are L - A, which is greater than L.
- R4: A read linked to several unissued writes stays not known until the last of them issues. Its cycles are then the maximum of max(0, L_i - A_i) over its links, where each L_i is that write's latency at its own issue, whatever ticks came between the issues.
- R5: A link to a write that has already issued makes the read known on the next cycle, with cycles max(0, C - A). C is the write's remaining count, which equals L minus the number of ticks since the issue.
- R6: Each tick lowers a known read's cycles by one, down to a floor of zero. Ready means known with zero cycles. With no tick, no link and no issue, the outputs hold.
- R7: A write's remaining count keeps falling below zero and is treated as signed: latency 2 followed by 4 ticks and advance -3 gives 1 cycle. The count saturates at -2^(LAT_W+1).
- R8: Each write stores up to USERS pending links. A link to an unissued write whose table is full sets `link_err_o` for exactly one cycle. That link is dropped, and it adds no outstanding write to the read.
- R9: Issuing a write that has already issued has no effect. Its count keeps running from the first issue.
- R10: An issue on the same edge as a tick loads the full latency. A link made on the same edge to the write being issued uses that latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One elapsed machine cycle |
| issue_valid_i | input | 1 | Issue a write slot |
| issue_wr_i | input | $clog2(N_WR) | Write slot being issued |
| issue_lat_i | input | LAT_W | Latency of the issued write |
| link_valid_i | input | 1 | Link a read slot to a write slot |
| link_rd_i | input | $clog2(N_RD) | Read slot of the link |
| link_wr_i | input | $clog2(N_WR) | Write slot of the link |
| link_adv_i | input | ADV_W | Signed read-advance of the link |
| link_err_o | output | 1 | Link dropped because the write's user table was full |
| rd_known_o | output | N_RD | Read cycle count is known |
| rd_ready_o | output | N_RD | Read is known with zero cycles left |
| rd_cycles_o | output | N_RD x RD_W | Remaining cycles per read, zero while not known |

## Verification
Every result appears on the outputs one edge after the stimulus that causes it. This holds for a read's first known count, an immediate link, a tick's decrement and the error pulse. The bench therefore sets its inputs at a falling edge. It checks the outputs at the next falling edge, after exactly one rising edge has passed, and clears the inputs at that same point. Multi-step cases such as ticks between issues, or ticks before a late link, are built from these single-edge steps. The expected count is worked out by hand from the latency, the ticks counted and the advance, with the floor at zero applied.

// File: rtl/lat_trk_pkg.sv
package lat_trk_pkg;
  localparam int DEF_N_RD  = 8;
  localparam int DEF_N_WR  = 8;
  localparam int DEF_USERS = 4;
  localparam int DEF_LAT_W = 4;
  localparam int DEF_ADV_W = 4;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lat_trk_wr.sv
module lat_trk_wr #(
  parameter int USERS  = 4,
  parameter int RIDX_W = 3,
  parameter int LAT_W  = 4,
  parameter int ADV_W  = 4,
  parameter int WR_W   = 6
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              tick_i,
  input  logic                              fire_i,
  input  logic [LAT_W-1:0]                  lat_i,
  input  logic                              store_i,
  input  logic [RIDX_W-1:0]                 store_rd_i,
  input  logic [ADV_W-1:0]                  store_adv_i,
  output logic                              known_o,
  output logic signed [WR_W-1:0]            cnt_o,
  output logic                              full_o,
  output logic [USERS-1:0]                  usr_v_o,
  output logic [USERS-1:0][RIDX_W-1:0]      usr_rd_o,
  output logic [USERS-1:0][ADV_W-1:0]       usr_adv_o
);
  localparam int UIDX_W = lat_trk_pkg::idx_w(USERS);
  localparam logic signed [WR_W-1:0] CNT_MIN = {1'b1, {(WR_W-1){1'b0}}};
  localparam logic signed [WR_W-1:0] CNT_ONE = 1;

  logic [UIDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    full_o   = 1'b1;
    for (int u = USERS-1; u >= 0; u--) begin
      if (!usr_v_o[u]) begin
        free_idx = UIDX_W'(u);
        full_o   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      known_o   <= 1'b0;
      cnt_o     <= '0;
      usr_v_o   <= '0;
      usr_rd_o  <= '0;
      usr_adv_o <= '0;
    end else if (fire_i) begin
      known_o <= 1'b1;
      cnt_o   <= $signed({{(WR_W-LAT_W){1'b0}}, lat_i});
      usr_v_o <= '0;
    end else begin
      // signed count runs past zero; saturate to avoid wrap
      if (tick_i && known_o && cnt_o != CNT_MIN) cnt_o <= cnt_o - CNT_ONE;
      if (store_i && !full_o) begin
        usr_v_o[free_idx]   <= 1'b1;
        usr_rd_o[free_idx]  <= store_rd_i;
        usr_adv_o[free_idx] <= store_adv_i;
      end
    end
  end
endmodule

// File: rtl/lat_trk_rd.sv
module lat_trk_rd #(
  parameter int RD_W = 5,
  parameter int PW   = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            inc_i,
  input  logic            note_i,
  input  logic [PW-1:0]   dec_i,
  input  logic [RD_W-1:0] dmax_i,
  output logic            known_o,
  output logic            ready_o,
  output logic [RD_W-1:0] cyc_o
);
  logic [PW-1:0]   pend_q, pend_d;
  logic [RD_W-1:0] val_q, val_d, ticked;
  logic            known_d;

  // val_q: running max while unknown, live count once known
  always_comb begin
    ticked = (known_o && tick_i && val_q != '0) ? val_q - RD_W'(1) : val_q;
    val_d  = (note_i && dmax_i > ticked) ? dmax_i : ticked;
    pend_d = pend_q + PW'(inc_i) - dec_i;
    known_d = (pend_d == '0) && (known_o || note_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      val_q   <= '0;
      known_o <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      val_q   <= val_d;
      known_o <= known_d;
    end
  end

  assign cyc_o   = known_o ? val_q : '0;
  assign ready_o = known_o && (val_q == '0);
endmodule

// File: rtl/lat_trk.sv
module lat_trk
  import lat_trk_pkg::*;
#(
  parameter int N_RD  = DEF_N_RD,
  parameter int N_WR  = DEF_N_WR,
  parameter int USERS = DEF_USERS,
  parameter int LAT_W = DEF_LAT_W,
  parameter int ADV_W = DEF_ADV_W,
  localparam int RIDX_W = idx_w(N_RD),
  localparam int WIDX_W = idx_w(N_WR),
  localparam int RD_W   = ((LAT_W > ADV_W-1) ? LAT_W : ADV_W-1) + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic                       issue_valid_i,
  input  logic [WIDX_W-1:0]          issue_wr_i,
  input  logic [LAT_W-1:0]           issue_lat_i,
  input  logic                       link_valid_i,
  input  logic [RIDX_W-1:0]          link_rd_i,
  input  logic [WIDX_W-1:0]          link_wr_i,
  input  logic [ADV_W-1:0]           link_adv_i,
  output logic                       link_err_o,
  output logic [N_RD-1:0]            rd_known_o,
  output logic [N_RD-1:0]            rd_ready_o,
  output logic [N_RD-1:0][RD_W-1:0]  rd_cycles_o
);
  localparam int WR_W = LAT_W + 2;
  localparam int MX   = (WR_W > ADV_W) ? WR_W : ADV_W;
  localparam int DW   = MX + 2;
  localparam int PW   = $clog2(N_WR*USERS + 2) + 1;

  logic [N_WR-1:0]                  wk, fire, full, store;
  logic signed [WR_W-1:0]           wcnt [N_WR];
  logic [USERS-1:0]                 uv   [N_WR];
  logic [USERS-1:0][RIDX_W-1:0]     urd  [N_WR];
  logic [USERS-1:0][ADV_W-1:0]      uadv [N_WR];

  logic [N_RD-1:0]                  inc, note;
  logic [PW-1:0]                    dec  [N_RD];
  logic [RD_W-1:0]                  dmax [N_RD];
  logic                             imm, store_ok, err_d;
  logic signed [DW-1:0]             lat_s, imm_base;

  function automatic logic signed [DW-1:0] sx_adv(input logic [ADV_W-1:0] a);
    return $signed({{(DW-ADV_W){a[ADV_W-1]}}, a});
  endfunction

  function automatic logic [RD_W-1:0] clamp0(input logic signed [DW-1:0] d);
    if (d < 0) return '0;
    return d[RD_W-1:0];
  endfunction

  for (genvar w = 0; w < N_WR; w++) begin : g_wr
    assign fire[w]  = issue_valid_i && issue_wr_i == WIDX_W'(w) && !wk[w];
    assign store[w] = store_ok && link_wr_i == WIDX_W'(w);
    lat_trk_wr #(
      .USERS(USERS), .RIDX_W(RIDX_W), .LAT_W(LAT_W), .ADV_W(ADV_W), .WR_W(WR_W)
    ) u_wr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .fire_i     (fire[w]),
      .lat_i      (issue_lat_i),
      .store_i    (store[w]),
      .store_rd_i (link_rd_i),
      .store_adv_i(link_adv_i),
      .known_o    (wk[w]),
      .cnt_o      (wcnt[w]),
      .full_o     (full[w]),
      .usr_v_o    (uv[w]),
      .usr_rd_o   (urd[w]),
      .usr_adv_o  (uadv[w])
    );
  end

  // link to a write that has issued, or issues now, resolves at once
  always_comb begin
    lat_s    = $signed({{(DW-LAT_W){1'b0}}, issue_lat_i});
    imm      = link_valid_i && (wk[link_wr_i] || fire[link_wr_i]);
    imm_base = wk[link_wr_i] ? $signed({{(DW-WR_W){wcnt[link_wr_i][WR_W-1]}}, wcnt[link_wr_i]})
                             : lat_s;
    store_ok = link_valid_i && !imm && !full[link_wr_i];
    err_d    = link_valid_i && !imm && full[link_wr_i];
  end

  always_comb begin
    for (int r = 0; r < N_RD; r++) begin
      dec[r]  = '0;
      dmax[r] = '0;
      note[r] = 1'b0;
      inc[r]  = store_ok && link_rd_i == RIDX_W'(r);
      for (int w = 0; w < N_WR; w++) begin
        for (int u = 0; u < USERS; u++) begin
          if (fire[w] && uv[w][u] && urd[w][u] == RIDX_W'(r)) begin
            dec[r]  = dec[r] + PW'(1);
            note[r] = 1'b1;
            if (clamp0(lat_s - sx_adv(uadv[w][u])) > dmax[r])
              dmax[r] = clamp0(lat_s - sx_adv(uadv[w][u]));
          end
        end
      end
      if (imm && link_rd_i == RIDX_W'(r)) begin
        note[r] = 1'b1;
        if (clamp0(imm_base - sx_adv(link_adv_i)) > dmax[r])
          dmax[r] = clamp0(imm_base - sx_adv(link_adv_i));
      end
    end
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    lat_trk_rd #(.RD_W(RD_W), .PW(PW)) u_rd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .inc_i  (inc[r]),
      .note_i (note[r]),
      .dec_i  (dec[r]),
      .dmax_i (dmax[r]),
      .known_o(rd_known_o[r]),
      .ready_o(rd_ready_o[r]),
      .cyc_o  (rd_cycles_o[r])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_err_o <= 1'b0;
    else         link_err_o <= err_d;
  end
endmodule

// File: rtl/lat_trk_chk.sv
module lat_trk_chk #(
  parameter int N_RD = 8,
  parameter int RD_W = 5
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      tick_i,
  input logic                      issue_valid_i,
  input logic                      link_valid_i,
  input logic                      link_err_o,
  input logic [N_RD-1:0]           rd_known_o,
  input logic [N_RD-1:0]           rd_ready_o,
  input logic [N_RD-1:0][RD_W-1:0] rd_cycles_o
);
  // R6
  hold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !link_valid_i && !issue_valid_i) |=>
      ($stable(rd_cycles_o) && $stable(rd_known_o)));

  // R2
  known_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_valid_i && !issue_valid_i) |=> ((rd_known_o & ~$past(rd_known_o)) == '0));

  // R8
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_err_o |-> $past(link_valid_i));

  for (genvar g = 0; g < N_RD; g++) begin : g_chk
    // R6
    tick_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !link_valid_i && !issue_valid_i && rd_known_o[g] && rd_cycles_o[g] != '0)
        |=> (rd_cycles_o[g] == $past(rd_cycles_o[g]) - RD_W'(1)));

    // R1
    unknown_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_known_o[g] |-> (rd_cycles_o[g] == '0 && !rd_ready_o[g]));

    // R6
    ready_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_ready_o[g] |-> (rd_known_o[g] && rd_cycles_o[g] == '0));
  end
endmodule

bind lat_trk lat_trk_chk #(.N_RD(N_RD), .RD_W(RD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .issue_valid_i(issue_valid_i),
  .link_valid_i (link_valid_i),
  .link_err_o   (link_err_o),
  .rd_known_o   (rd_known_o),
  .rd_ready_o   (rd_ready_o),
  .rd_cycles_o  (rd_cycles_o)
);

// File: tb/lat_trk_bench.sv
`timescale 1ns/1ps
module lat_trk_bench;
  localparam int N_RD = 8;
  localparam int RD_W = 5;

  logic                       clk = 1'b0;
  logic                       rst_ni = 1'b0;
  logic                       tick_i = 1'b0;
  logic                       issue_valid_i = 1'b0;
  logic [2:0]                 issue_wr_i = '0;
  logic [3:0]                 issue_lat_i = '0;
  logic                       link_valid_i = 1'b0;
  logic [2:0]                 link_rd_i = '0;
  logic [2:0]                 link_wr_i = '0;
  logic [3:0]                 link_adv_i = '0;
  logic                       link_err_o;
  logic [N_RD-1:0]            rd_known_o, rd_ready_o;
  logic [N_RD-1:0][RD_W-1:0]  rd_cycles_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lat_trk u_lat_trk (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .issue_valid_i(issue_valid_i), .issue_wr_i(issue_wr_i), .issue_lat_i(issue_lat_i),
    .link_valid_i(link_valid_i), .link_rd_i(link_rd_i), .link_wr_i(link_wr_i),
    .link_adv_i(link_adv_i), .link_err_o(link_err_o),
    .rd_known_o(rd_known_o), .rd_ready_o(rd_ready_o), .rd_cycles_o(rd_cycles_o)
  );

  function automatic int clamp0(input int x);
    return (x < 0) ? 0 : x;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rd(input string req, input int r, input bit kn, input int cy);
    chk(req, $sformatf("known[%0d]", r), int'(rd_known_o[r]), int'(kn));
    chk(req, $sformatf("ready[%0d]", r), int'(rd_ready_o[r]), int'(kn && cy == 0));
    chk(req, $sformatf("cycles[%0d]", r), int'(rd_cycles_o[r]), kn ? cy : 0);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // drive at a falling edge, pass one rising edge, clear at the next falling edge
  task automatic op(input bit tk, input bit iss, input int iw, input int il,
                    input bit lnk, input int lr, input int lw, input int la);
    tick_i        = tk;
    issue_valid_i = iss;
    issue_wr_i    = 3'(iw);
    issue_lat_i   = 4'(il);
    link_valid_i  = lnk;
    link_rd_i     = 3'(lr);
    link_wr_i     = 3'(lw);
    link_adv_i    = 4'(la);
    @(negedge clk);
    tick_i = 1'b0; issue_valid_i = 1'b0; link_valid_i = 1'b0;
  endtask

  task automatic tick();                       op(1, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic idle();                       op(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic issue(input int w, input int l); op(0, 1, w, l, 0, 0, 0, 0); endtask
  task automatic link(input int r, input int w, input int a); op(0, 0, 0, 0, 1, r, w, a); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1 reset state
    for (int r = 0; r < N_RD; r++) chk_rd("R1", r, 0, 0);
    chk("R1", "link_err", int'(link_err_o), 0);

    // R2 / R3 sweep of latency and advance
    for (int l = 0; l < 16; l++) begin
      for (int a = -8; a < 8; a++) begin
        do_reset();
        link(0, 0, a);
        chk_rd("R2", 0, 0, 0);
        issue(0, l);
        chk_rd((a < 0) ? "R3" : "R2", 0, 1, clamp0(l - a));
        if (a < 0) chk("R3", "longer than latency", int'(rd_cycles_o[0] > 5'(l)), 1);
      end
    end

    // R6 countdown to zero and hold
    do_reset();
    link(1, 2, -2);
    issue(2, 5);
    chk_rd("R6", 1, 1, 7);
    for (int n = 1; n <= 9; n++) begin
      tick();
      chk_rd("R6", 1, 1, clamp0(7 - n));
    end
    idle();
    chk_rd("R6", 1, 1, 0);
    do_reset();
    link(3, 1, 0);
    issue(1, 6);
    idle();
    idle();
    chk_rd("R6", 3, 1, 6);

    // R5 / R7 late link after k ticks
    for (int l = 0; l < 16; l += 5) begin
      for (int k = 0; k <= l + 3; k++) begin
        for (int a = -8; a < 8; a += 3) begin
          do_reset();
          issue(3, l);
          for (int t = 0; t < k; t++) tick();
          link(2, 3, a);
          chk_rd((l - k < 0) ? "R7" : "R5", 2, 1, clamp0(l - k - a));
        end
      end
    end
    do_reset();
    issue(4, 2);
    repeat (4) tick();
    link(6, 4, -3);
    chk_rd("R7", 6, 1, 1);

    // R4 several partial writes, worst case wins
    for (int p = 0; p < 4; p++) begin
      int a0, a1, a2, l0, l1, l2, e;
      a0 = p - 2; a1 = 3 - 2 * p; a2 = -p;
      l0 = 4 + p; l1 = 2 * p;     l2 = 9 - p;
      e = clamp0(l0 - a0);
      if (clamp0(l1 - a1) > e) e = clamp0(l1 - a1);
      if (clamp0(l2 - a2) > e) e = clamp0(l2 - a2);
      do_reset();
      link(5, 0, a0);
      link(5, 1, a1);
      link(5, 4, a2);
      issue(0, l0);
      chk_rd("R4", 5, 0, 0);
      tick();
      issue(1, l1);
      chk_rd("R4", 5, 0, 0);
      tick();
      issue(4, l2);
      chk_rd("R4", 5, 1, e);
    end

    // R8 full user table
    do_reset();
    for (int r = 0; r < 4; r++) begin
      link(r, 6, 0);
      chk("R8", "link_err while space", int'(link_err_o), 0);
    end
    link(4, 6, 0);
    chk("R8", "link_err on full", int'(link_err_o), 1);
    idle();
    chk("R8", "link_err one cycle", int'(link_err_o), 0);
    chk_rd("R8", 4, 0, 0);
    issue(7, 3);
    link(4, 7, 1);
    chk_rd("R8", 4, 1, 2);
    issue(6, 2);
    for (int r = 0; r < 4; r++) chk_rd("R8", r, 1, 2);

    // R9 second issue ignored
    do_reset();
    issue(0, 5);
    tick();
    tick();
    issue(0, 9);
    link(0, 0, 0);
    chk_rd("R9", 0, 1, 3);

    // R10 issue with tick and link on one edge
    do_reset();
    op(1, 1, 0, 6, 1, 0, 0, 1);
    chk_rd("R10", 0, 1, 5);
    tick();
    chk_rd("R10", 0, 1, 4);
    link(1, 0, 0);
    chk_rd("R10", 1, 1, 5);
    chk_rd("R10", 0, 1, 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule